// File: doc/BRIEF.md
# Flash command and status controller

This block interprets bus write cycles for a word-wide NOR flash array model and sequences abstract program and erase operations. Single-cycle and two-cycle command codes select how reads are answered: stored words, an 8-bit status register, query data or identification data. Program and erase run on parameterised cycle timers. Either operation can be suspended and later resumed. A program may run while an erase is suspended, and that program may itself be suspended.

Error bits in the status register are sticky, so several operations can be run before software checks for failure. Only the clear-status command or a reset removes them. The machine sets and clears its own ready and suspend bits. Two inputs come from outside: a locked flag for each sector and a programming-voltage-good flag. The storage is a small behavioural RAM that resets to the erased value.

Read data is captured on the rising edge of the read strobe and held while the strobe stays high. A poller must therefore toggle the strobe to see a new status value.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block answers reads from the array, every stored word reads FFFFh, and the status register reads 80h.
- R2: Writing FFh selects array reads from status, query or identification mode whenever no operation is actively running.
- R3: Program is 40h at any address, then the data at the target address. The stored word becomes old AND new. Status bit 7 reads 0 for PROG_CYC cycles after the data cycle and then reads 1.
- R4: Erase is 20h, then D0h at any address inside the sector. Every word of that sector becomes FFFFh and other sectors keep their contents. If the second cycle is anything other than D0h, status bits 4 and 5 are set and no erase starts.
- R5: 98h selects query reads, returning {00h, (address low byte) XOR 5Ah}. 90h selects identification reads, returning 0042h at even addresses and 0017h at odd addresses.
- R6: Status layout: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 voltage low, bit 2 program suspended, bit 1 locked-sector abort. Bit 0 and the upper data byte read 0.
- R7: Bits 1, 3, 4 and 5 stay set until 50h is written in idle or a reset occurs. Read-array and read-status commands do not clear them.
- R8: While a program or erase is running, only 70h and B0h have an effect. Any other write, including 50h, 98h, FFh and 20h, is ignored.
- R9: B0h during a running operation sets bit 7 and the matching suspend bit. D0h written alone while suspended clears that suspend bit and resumes the operation. The same codes serve both program and erase.
- R10: While an erase is suspended, 20h is ignored and a program is accepted. While a program is suspended, 40h is ignored.
- R11: A start aimed at a locked sector sets bit 1 and leaves the array untouched. A start with the voltage flag low sets bit 3 only, since the voltage check comes first. Both abort cases and every accepted start select status reads.
- R12: Read data is sampled when the read strobe rises and is held unchanged while the strobe stays high.
- R13: A program during a suspended erase shows status 40h while running. Suspending it shows C4h. The first D0h resumes the program, which finishes at C0h, and a later D0h resumes the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle, one clock per cycle |
| rd_en | input | 1 | Read strobe; data captured on its rising edge |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; the low byte carries command codes |
| rdata | output | 16 | Captured read data |
| sect_locked | input | 2**SECT_W | Per-sector locked flags |
| vpp_ok | input | 1 | Programming voltage is good |

## Verification
The bench builds the block with 64 words in four sectors of 16 words, a 12-cycle program and a 40-cycle erase. With so few words, every word is swept after each program and erase and compared with a mask-and-merge model. The query map is swept over all 64 addresses. The short timers let command writes land inside a busy window, and they keep each nested suspend and resume sequence to a few dozen cycles.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STAT   = 8'h70;
  localparam logic [7:0] OP_CLR_STAT    = 8'h50;
  localparam logic [7:0] OP_QUERY       = 8'h98;
  localparam logic [7:0] OP_IDENT       = 8'h90;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_SUSPEND     = 8'hB0;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_ARRAY, CMD_STATUS, CMD_CLEAR, CMD_QUERY, CMD_IDENT,
    CMD_PSETUP, CMD_ESETUP, CMD_SUSPEND, CMD_RESUME, CMD_PDATA,
    CMD_ECONF, CMD_ESEQERR
  } cmd_e;

  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE} pend_e;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_QUERY, RM_IDENT} rmode_e;

  typedef struct packed {
    logic prog_act;
    logic ers_act;
    logic prg_susp;
    logic ers_susp;
  } wsm_flags_t;

  typedef struct packed {
    logic sr1;
    logic sr3;
    logic sr4;
    logic sr5;
  } sticky_t;

  // An operation is running when it is active and not held.
  function automatic logic wsm_running(wsm_flags_t f);
    return (f.prog_act && !f.prg_susp) || (f.ers_act && !f.ers_susp);
  endfunction

  function automatic logic [7:0] pack_status(wsm_flags_t f, sticky_t s);
    return {!wsm_running(f), f.ers_susp, s.sr5, s.sr4, s.sr3, f.prg_susp, s.sr1, 1'b0};
  endfunction

  function automatic logic [15:0] query_word(logic [7:0] a);
    return {8'h00, a ^ 8'h5A};
  endfunction

  function automatic logic [15:0] ident_word(logic a0);
    return a0 ? 16'h0017 : 16'h0042;
  endfunction

  // Programming only clears bits.
  function automatic logic [15:0] prog_merge(logic [15:0] old_w, logic [15:0] new_w);
    return old_w & new_w;
  endfunction

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  input  wsm_flags_t flags,
  output cmd_e       cmd
);

  pend_e pend;

  function automatic cmd_e run_table(logic [7:0] b);
    case (b)
      OP_READ_STAT: return CMD_STATUS;
      OP_SUSPEND:   return CMD_SUSPEND;
      default:      return CMD_NONE;
    endcase
  endfunction

  function automatic cmd_e psusp_table(logic [7:0] b);
    case (b)
      OP_READ_STAT:  return CMD_STATUS;
      OP_READ_ARRAY: return CMD_ARRAY;
      OP_QUERY:      return CMD_QUERY;
      OP_IDENT:      return CMD_IDENT;
      OP_CONFIRM:    return CMD_RESUME;
      default:       return CMD_NONE;
    endcase
  endfunction

  function automatic cmd_e esusp_table(logic [7:0] b);
    if (b == OP_PROG_SETUP) return CMD_PSETUP;
    return psusp_table(b);
  endfunction

  function automatic cmd_e idle_table(logic [7:0] b);
    case (b)
      OP_READ_ARRAY:  return CMD_ARRAY;
      OP_READ_STAT:   return CMD_STATUS;
      OP_CLR_STAT:    return CMD_CLEAR;
      OP_QUERY:       return CMD_QUERY;
      OP_IDENT:       return CMD_IDENT;
      OP_PROG_SETUP:  return CMD_PSETUP;
      OP_ERASE_SETUP: return CMD_ESETUP;
      default:        return CMD_NONE;
    endcase
  endfunction

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (pend == PEND_PROG)       cmd = CMD_PDATA;
      else if (pend == PEND_ERASE) cmd = (wbyte == OP_CONFIRM) ? CMD_ECONF : CMD_ESEQERR;
      else if (wsm_running(flags)) cmd = run_table(wbyte);
      else if (flags.prg_susp)     cmd = psusp_table(wbyte);
      else if (flags.ers_susp)     cmd = esusp_table(wbyte);
      else                         cmd = idle_table(wbyte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= PEND_NONE;
    else if (wr_en) pend <= (cmd == CMD_PSETUP) ? PEND_PROG :
                            (cmd == CMD_ESETUP) ? PEND_ERASE : PEND_NONE;
  end

endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm
  import fcc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cmd_e                     cmd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [15:0]              wdata,
  input  logic [(1<<SECT_W)-1:0]   sect_locked,
  input  logic                     vpp_ok,
  output wsm_flags_t               flags,
  output logic [7:0]               status,
  output logic                     prog_fire,
  output logic [ADDR_W-1:0]        prog_addr,
  output logic [15:0]              prog_data,
  output logic                     erase_fire,
  output logic [SECT_W-1:0]        erase_sect,
  output logic                     ev_prog_start,
  output logic                     ev_erase_start,
  output logic                     ev_lock_abort,
  output logic                     ev_vpp_abort
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]  pcnt, ecnt;
  sticky_t           sticky;
  logic [SECT_W-1:0] tgt_sect;
  logic              start_req, prog_tick, erase_tick;

  assign tgt_sect       = addr[ADDR_W-1 -: SECT_W];
  assign start_req      = (cmd == CMD_PDATA) || (cmd == CMD_ECONF);
  assign ev_vpp_abort   = start_req && !vpp_ok;
  assign ev_lock_abort  = start_req && vpp_ok && sect_locked[tgt_sect];
  assign ev_prog_start  = (cmd == CMD_PDATA) && vpp_ok && !sect_locked[tgt_sect];
  assign ev_erase_start = (cmd == CMD_ECONF) && vpp_ok && !sect_locked[tgt_sect];

  assign prog_tick  = flags.prog_act && !flags.prg_susp;
  assign erase_tick = flags.ers_act && !flags.ers_susp;
  assign prog_fire  = prog_tick && (pcnt == CNT_W'(1));
  assign erase_fire = erase_tick && (ecnt == CNT_W'(1));

  assign status = pack_status(flags, sticky);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      sticky     <= '0;
      pcnt       <= '0;
      ecnt       <= '0;
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_sect <= '0;
    end else begin
      if (ev_prog_start) begin
        flags.prog_act <= 1'b1;
        pcnt           <= CNT_W'(PROG_CYC);
        prog_addr      <= addr;
        prog_data      <= wdata;
      end else if (prog_tick) begin
        if (prog_fire) flags.prog_act <= 1'b0;
        else           pcnt <= pcnt - 1'b1;
      end

      if (ev_erase_start) begin
        flags.ers_act <= 1'b1;
        ecnt          <= CNT_W'(ERASE_CYC);
        erase_sect    <= tgt_sect;
      end else if (erase_tick) begin
        if (erase_fire) flags.ers_act <= 1'b0;
        else            ecnt <= ecnt - 1'b1;
      end

      case (cmd)
        CMD_SUSPEND: begin
          if (prog_tick && !prog_fire)        flags.prg_susp <= 1'b1;
          else if (erase_tick && !erase_fire) flags.ers_susp <= 1'b1;
        end
        CMD_RESUME: begin
          if (flags.prg_susp) flags.prg_susp <= 1'b0;
          else                flags.ers_susp <= 1'b0;
        end
        CMD_CLEAR: sticky <= '0;
        CMD_ESEQERR: begin
          sticky.sr4 <= 1'b1;
          sticky.sr5 <= 1'b1;
        end
        default: ;
      endcase

      if (ev_vpp_abort)  sticky.sr3 <= 1'b1;
      if (ev_lock_abort) sticky.sr1 <= 1'b1;
    end
  end

endmodule

// File: rtl/fcc_array.sv
module fcc_array
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_fire,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [15:0]       prog_data,
  input  logic              erase_fire,
  input  logic [SECT_W-1:0] erase_sect,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_word
);

  localparam int WORDS   = 1 << ADDR_W;
  localparam int SECT_SH = ADDR_W - SECT_W;

  logic [15:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (erase_fire) begin
      for (int i = 0; i < WORDS; i++)
        if (SECT_W'(i >> SECT_SH) == erase_sect) mem[i] <= 16'hFFFF;
    end else if (prog_fire) begin
      mem[prog_addr] <= prog_merge(mem[prog_addr], prog_data);
    end
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [15:0]            wdata,
  output logic [15:0]            rdata,
  input  logic [(1<<SECT_W)-1:0] sect_locked,
  input  logic                   vpp_ok
);

  cmd_e              cmd;
  wsm_flags_t        flags;
  logic [7:0]        status;
  logic              prog_fire, erase_fire;
  logic [ADDR_W-1:0] prog_addr;
  logic [15:0]       prog_data;
  logic [SECT_W-1:0] erase_sect;
  logic              ev_prog_start, ev_erase_start, ev_lock_abort, ev_vpp_abort;
  logic [15:0]       arr_word, rd_mux;
  rmode_e            rmode;
  logic              rd_q, rd_rise;

  fcc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wbyte(wdata[7:0]),
    .flags(flags), .cmd(cmd)
  );

  fcc_wsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_wsm (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
    .sect_locked(sect_locked), .vpp_ok(vpp_ok), .flags(flags), .status(status),
    .prog_fire(prog_fire), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_fire(erase_fire), .erase_sect(erase_sect),
    .ev_prog_start(ev_prog_start), .ev_erase_start(ev_erase_start),
    .ev_lock_abort(ev_lock_abort), .ev_vpp_abort(ev_vpp_abort)
  );

  fcc_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_fire(prog_fire), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_fire(erase_fire), .erase_sect(erase_sect),
    .rd_addr(addr), .rd_word(arr_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rmode <= RM_ARRAY;
    else begin
      case (cmd)
        CMD_ARRAY:  rmode <= RM_ARRAY;
        CMD_QUERY:  rmode <= RM_QUERY;
        CMD_IDENT:  rmode <= RM_IDENT;
        CMD_STATUS, CMD_PDATA, CMD_ECONF, CMD_ESEQERR,
        CMD_SUSPEND, CMD_RESUME: rmode <= RM_STATUS;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rmode)
      RM_ARRAY:  rd_mux = arr_word;
      RM_STATUS: rd_mux = {8'h00, status};
      RM_QUERY:  rd_mux = query_word(8'(addr));
      default:   rd_mux = ident_word(addr[0]);
    endcase
  end

  assign rd_rise = rd_en && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      rdata <= '0;
    end else begin
      rd_q <= rd_en;
      if (rd_rise) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import fcc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [15:0] rdata,
  input cmd_e       cmd,
  input wsm_flags_t flags,
  input logic [7:0] status,
  input logic       ev_prog_start,
  input logic       ev_erase_start,
  input logic       ev_lock_abort,
  input logic       ev_vpp_abort
);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status) & ~status & 8'h3A)) |-> ($past(cmd) == CMD_CLEAR));

  // R9
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[7]);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0]);

  // R11
  lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_abort |=> (status[1] && $stable(flags)));

  // R11
  vpp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vpp_abort |=> (status[3] && $stable(flags)));

  // R3
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog_start |=> !status[7]);

  // R4
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase_start |=> !status[7]);

  // R8
  run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] && cmd != CMD_NONE) |-> (cmd == CMD_STATUS || cmd == CMD_SUSPEND));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |=> $stable(rdata));

endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata), .cmd(cmd),
  .flags(flags), .status(status), .ev_prog_start(ev_prog_start),
  .ev_erase_start(ev_erase_start), .ev_lock_abort(ev_lock_abort),
  .ev_vpp_abort(ev_vpp_abort)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

  localparam int AW = 6;
  localparam int SW = 2;
  localparam int PC = 12;
  localparam int EC = 40;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [3:0]    sect_locked = '0;
  logic          vpp_ok = 1'b1;

  int vec = 0;
  int err = 0;
  logic [15:0] model [NW];

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sect_locked(sect_locked), .vpp_ok(vpp_ok)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vec++;
    if (got !== exp) begin
      err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n, output logic [15:0] s);
    n = 0;
    s = '0;
    do begin
      rd('0, s);
      n++;
    end while (!s[7] && n < 400);
  endtask

  task automatic sweep(input string tag);
    logic [15:0] d;
    wr('0, 16'h00FF);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), d);
      chk(tag, d, model[a]);
    end
  endtask

  task automatic stat_is(input string tag, input logic [15:0] exp);
    logic [15:0] s;
    rd('0, s);
    chk(tag, s, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    err++;
    vec++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    int n;
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: erased array, array reads, ready status
    sweep("R1 erased after reset");
    wr('0, 16'h0070);
    stat_is("R1 R6 status after reset", 16'h0080);

    // R5: query sweep and identification
    wr('0, 16'h0098);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), v);
      chk("R5 query", v, {8'h00, 8'(a) ^ 8'h5A});
    end
    wr('0, 16'h0090);
    rd(6'd4, v); chk("R5 ident even", v, 16'h0042);
    rd(6'd7, v); chk("R5 ident odd", v, 16'h0017);
    wr('0, 16'h00FF);
    rd(6'd9, v); chk("R2 array after ident", v, 16'hFFFF);

    // R3: program sector 1, timing of first program
    for (int i = 16; i < 32; i++) begin
      logic [15:0] p;
      p = 16'hA5C3 ^ 16'(i * 16'h0111);
      wr('0, 16'h0040);
      wr(AW'(i), p);
      model[i] = model[i] & p;
      wait_ready(n, v);
      if (i == 16) chk("R3 busy window", 16'(n >= 6 && n <= 8), 16'h0001);
      chk("R3 R6 ready after program", v, 16'h0080);
    end
    wr('0, 16'h0040);
    wr(6'd16, 16'h0FF0);
    model[16] = model[16] & 16'h0FF0;
    wait_ready(n, v);
    sweep("R3 program merge");

    // R4: erase sector 2
    wr('0, 16'h0040); wr(6'd40, 16'h1234); wait_ready(n, v);
    wr('0, 16'h0040); wr(6'd41, 16'h0000); wait_ready(n, v);
    wr(6'd32, 16'h0020);
    wr(6'd37, 16'h00D0);
    rd('0, v); chk("R4 erase busy", v, 16'h0000);
    wait_ready(n, v);
    chk("R4 erase done", v, 16'h0080);
    sweep("R4 erase sector only");

    // R4, R7: sequence error and sticky bits
    wr('0, 16'h0020);
    wr('0, 16'h00FF);
    stat_is("R4 sequence error", 16'h00B0);
    wr('0, 16'h00FF);
    wr('0, 16'h0070);
    stat_is("R7 sticky after read commands", 16'h00B0);
    wr('0, 16'h0050);
    stat_is("R7 clear status", 16'h0080);

    // R11: locked sector and voltage abort
    sect_locked = 4'b1000;
    wr('0, 16'h0040); wr(6'd50, 16'h0000);
    stat_is("R11 locked abort", 16'h0082);
    wr('0, 16'h00FF);
    rd(6'd50, v); chk("R11 locked word unchanged", v, model[50]);
    wr('0, 16'h0050);
    vpp_ok = 1'b0;
    wr('0, 16'h0040); wr(6'd50, 16'h0000);
    stat_is("R11 voltage first", 16'h0088);
    wr('0, 16'h0050);
    wr(6'd48, 16'h0020); wr(6'd48, 16'h00D0);
    stat_is("R11 erase voltage low", 16'h0088);
    wr('0, 16'h0050);
    vpp_ok = 1'b1;
    wr(6'd48, 16'h0020); wr(6'd48, 16'h00D0);
    stat_is("R11 erase locked", 16'h0082);

    // R8: commands ignored during a running program
    wr('0, 16'h0040); wr(6'd5, 16'h00F0);
    model[5] = model[5] & 16'h00F0;
    wr('0, 16'h0098);
    wr('0, 16'h0050);
    wr('0, 16'h00FF);
    wr('0, 16'h0020);
    wait_ready(n, v);
    chk("R8 ignored while busy", v, 16'h0082);
    wr('0, 16'h0050);
    stat_is("R7 clear after busy", 16'h0080);

    // R9, R10: program suspend
    wr('0, 16'h0040); wr(6'd6, 16'h0F0F);
    wr('0, 16'h00B0);
    stat_is("R9 program suspended", 16'h0084);
    wr('0, 16'h0040); wr(6'd7, 16'h0000);
    stat_is("R10 program rejected in program suspend", 16'h0084);
    wr('0, 16'h00FF);
    rd(6'd7, v); chk("R10 other word untouched", v, model[7]);
    rd(6'd6, v); chk("R9 held word not yet written", v, model[6]);
    wr('0, 16'h00D0);
    model[6] = model[6] & 16'h0F0F;
    wait_ready(n, v);
    chk("R9 program resumed and done", v, 16'h0080);

    // R13, R9, R10: nested suspend
    wr('0, 16'h0020); wr('0, 16'h00D0);
    wr('0, 16'h00B0);
    stat_is("R9 erase suspended", 16'h00C0);
    wr('0, 16'h0020); wr('0, 16'h0070);
    stat_is("R10 second erase rejected", 16'h00C0);
    wr('0, 16'h0040); wr(6'd20, 16'h3C3C);
    model[20] = model[20] & 16'h3C3C;
    stat_is("R13 program in erase suspend", 16'h0040);
    wr('0, 16'h00B0);
    stat_is("R13 both suspended", 16'h00C4);
    wr('0, 16'h00D0);
    stat_is("R13 program resumed first", 16'h0040);
    wait_ready(n, v);
    chk("R13 program done erase still held", v, 16'h00C0);
    wr('0, 16'h00D0);
    stat_is("R13 erase resumed", 16'h0000);
    for (int i = 0; i < 16; i++) model[i] = 16'hFFFF;
    wait_ready(n, v);
    chk("R13 erase done", v, 16'h0080);
    sweep("R13 array after nested");

    // R12: held strobe keeps captured status
    wr('0, 16'h0040); wr(6'd9, 16'hFFFE);
    model[9] = model[9] & 16'hFFFE;
    rd_en = 1'b1; addr = '0;
    @(negedge clk);
    chk("R12 captured busy", rdata, 16'h0000);
    repeat (PC + 4) @(negedge clk);
    chk("R12 held while strobe high", rdata, 16'h0000);
    rd_en = 1'b0;
    @(negedge clk);
    stat_is("R12 new value after toggle", 16'h0080);
    sweep("R3 final array");

    // R7, R1: reset clears sticky bits and array
    wr('0, 16'h0020); wr('0, 16'h0000);
    stat_is("R7 sticky before reset", 16'h00B0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'd20, v); chk("R1 array mode after reset", v, 16'hFFFF);
    wr('0, 16'h0070);
    stat_is("R7 reset clears sticky", 16'h0080);

    summary();
  end

endmodule